// File: doc/BRIEF.md
# Indirect PHY Register Access Bridge

This block lets a host processor reach the internal configuration registers of a physical-layer block without wiring that register file onto the system bus. The host sees six 32-bit access registers. It loads the data to write, sets a lane-enable bit, and then writes a command word that holds a register index, a register-group select and a read or write request. The bridge turns that command into a single request on a narrow request/acknowledge bus towards the PHY. When the PHY acknowledges, the bridge sets a done flag and, for a read, captures the returned data. The host polls the flag and finishes by writing a command word with no request bits, which returns the bridge to idle.

The bridge also holds a two-bit reset register whose bits drive the PHY's main reset and soft reset directly. A cycle counter guards each transaction. If the PHY never answers, the request is withdrawn and an error flag is raised, so the host never waits forever.

Top module: `phy_reg_bridge`

## Requirements
- R1: After reset, every access register reads zero, `phy_req` is 0, and both PHY reset outputs are 0.
- R2: Register offsets are 0x00 command, 0x04 write data, 0x08 lane enable (bit 0 only), 0x0C reset (bits 1:0), 0x10 read data and 0x14 status. The first four read back what was written, with unused bits reading as zero. Host writes to 0x10 and 0x14 have no effect. Offsets 0x18 and 0x1C read zero.
- R3: Reset register bit 1 drives `phy_rst` and bit 0 drives `phy_soft_rst`, from the cycle after the write. Writing zero deasserts both.
- R4: The command word has bits 7:0 for the register index, bit 8 for a write request, bit 9 for a read request and bit 10 for the group select. A command write whose bits 9:8 change from 00 to 01 or 10 starts exactly one transaction. `phy_req` rises in the next cycle, and `phy_index`, `phy_group`, `phy_we` and `phy_wdata` (taken from the write-data register) stay stable while it is high. `phy_lane` follows lane-enable bit 0.
- R5: `phy_req` stays high until the PHY raises `phy_ack`. At that clock edge `phy_req` falls and status bit 0 (done) is set.
- R6: For a read, the read-data register takes `phy_rdata` at the same edge that sets done. A write leaves the read-data register unchanged.
- R7: A command write with bits 9:8 = 11 starts no transaction.
- R8: A command write while bits 9:8 are already non-zero starts no new transaction and leaves the done flag as it is.
- R9: A command write with bits 9:8 = 00 clears done and error, and withdraws any request in flight from the next cycle.
- R10: If `phy_ack` has not come after TIMEOUT_CYC cycles of `phy_req`, the request falls, status bit 1 (error) is set and done stays 0.
- R11: A `phy_ack` pulse while no request is pending changes neither the status nor the read-data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host byte offset |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data for `host_addr` (combinational) |
| phy_req | output | 1 | Transaction request to the PHY |
| phy_we | output | 1 | 1 = write transaction, 0 = read |
| phy_group | output | 1 | Register group select |
| phy_index | output | IDX_W | PHY register index |
| phy_wdata | output | DATA_W | Data for a write transaction |
| phy_lane | output | 1 | Lane enable |
| phy_ack | input | 1 | PHY completion pulse |
| phy_rdata | input | DATA_W | PHY read data, valid with `phy_ack` |
| phy_rst | output | 1 | PHY main reset |
| phy_soft_rst | output | 1 | PHY soft reset |

## Verification
A wrong transaction state shows up at the PHY pins within one cycle. Examples are a request that starts on a stale command, fails to drop on an acknowledge, or changes its index while pending. A stuck or missing done flag shows up in the host's next poll of the status register. A wrong timeout count shows up as an error flag that comes too early or too late. The bench measures the exact length of the request for this case. A captured read value that is lost or overwritten shows up as a wrong read-data word in the first read after the transaction.

// File: rtl/phy_bridge_pkg.sv
package phy_bridge_pkg;

  // word indices of the access registers (byte offset / 4)
  localparam int unsigned WI_CMD   = 0;
  localparam int unsigned WI_WDATA = 1;
  localparam int unsigned WI_LANE  = 2;
  localparam int unsigned WI_RST   = 3;
  localparam int unsigned WI_RDATA = 4;
  localparam int unsigned WI_STAT  = 5;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_BAD   = 2'b11
  } op_e;

  function automatic op_e op_of(input logic [1:0] bits);
    return op_e'(bits);
  endfunction

  // a request may start only when the old request bits were idle and the
  // new bits name exactly one operation
  function automatic logic op_starts(input logic [1:0] old_bits,
                                     input logic [1:0] new_bits);
    return (op_of(old_bits) == OP_NONE) &&
           ((op_of(new_bits) == OP_WRITE) || (op_of(new_bits) == OP_READ));
  endfunction

  function automatic logic op_is_bad(input logic [1:0] bits);
    return op_of(bits) == OP_BAD;
  endfunction

  function automatic logic op_is_idle(input logic [1:0] bits);
    return op_of(bits) == OP_NONE;
  endfunction

endpackage

// File: rtl/phy_bridge_timer.sv
module phy_bridge_timer #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expire
);
  localparam int unsigned CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr)     cnt_q <= '0;
    else if (en)      cnt_q <= cnt_q + 1'b1;
  end

  assign expire = en && (cnt_q == CNT_W'(LIMIT - 1));

endmodule

// File: rtl/phy_bridge_regs.sv
module phy_bridge_regs
  import phy_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [DATA_W-1:0] rd_data_q,
  input  logic              done_flag,
  input  logic              err_flag,
  output logic [IDX_W-1:0]  cmd_index,
  output logic              cmd_read,
  output logic              cmd_group,
  output logic [DATA_W-1:0] wdata_q,
  output logic              lane_q,
  output logic [1:0]        rst_bits_q,
  output logic              start_evt,
  output logic              clear_evt,
  output logic              bad_evt
);
  localparam int unsigned CMD_W  = IDX_W + 3;
  localparam int unsigned WR_BIT = IDX_W;
  localparam int unsigned GRP_BIT = IDX_W + 2;
  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic [CMD_W-1:0]  cmd_q;
  logic [WIDX_W-1:0] widx;
  logic              cmd_wr;
  logic [1:0]        new_ops;
  logic [1:0]        old_ops;
  logic              unused_bits;

  assign widx    = host_addr[ADDR_W-1:2];
  assign cmd_wr  = host_we && (widx == WIDX_W'(WI_CMD));
  assign new_ops = host_wdata[WR_BIT+1:WR_BIT];
  assign old_ops = cmd_q[WR_BIT+1:WR_BIT];

  assign start_evt = cmd_wr && op_starts(old_ops, new_ops);
  assign clear_evt = cmd_wr && op_is_idle(new_ops);
  assign bad_evt   = cmd_wr && op_is_bad(new_ops);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      wdata_q    <= '0;
      lane_q     <= 1'b0;
      rst_bits_q <= 2'b00;
    end else if (host_we) begin
      case (widx)
        WIDX_W'(WI_CMD):   cmd_q      <= host_wdata[CMD_W-1:0];
        WIDX_W'(WI_WDATA): wdata_q    <= host_wdata;
        WIDX_W'(WI_LANE):  lane_q     <= host_wdata[0];
        WIDX_W'(WI_RST):   rst_bits_q <= host_wdata[1:0];
        default: ;
      endcase
    end
  end

  assign cmd_index = cmd_q[IDX_W-1:0];
  assign cmd_read  = op_of(old_ops) == OP_READ;
  assign cmd_group = cmd_q[GRP_BIT];

  always_comb begin
    host_rdata = '0;
    case (widx)
      WIDX_W'(WI_CMD):   host_rdata = {{(DATA_W-CMD_W){1'b0}}, cmd_q};
      WIDX_W'(WI_WDATA): host_rdata = wdata_q;
      WIDX_W'(WI_LANE):  host_rdata = {{(DATA_W-1){1'b0}}, lane_q};
      WIDX_W'(WI_RST):   host_rdata = {{(DATA_W-2){1'b0}}, rst_bits_q};
      WIDX_W'(WI_RDATA): host_rdata = rd_data_q;
      WIDX_W'(WI_STAT):  host_rdata = {{(DATA_W-2){1'b0}}, err_flag, done_flag};
      default:           host_rdata = '0;
    endcase
  end

  assign unused_bits = ^{host_addr[1:0], host_wdata[DATA_W-1:CMD_W]};

  // R7: a double request never raises the start event
  p_bad_no_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_evt |-> !start_evt);

endmodule

// File: rtl/phy_bridge_xact.sv
module phy_bridge_xact #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned IDX_W       = 8,
  parameter int unsigned TIMEOUT_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              clear_evt,
  input  logic              bad_evt,
  input  logic              start_read,
  input  logic              start_group,
  input  logic [IDX_W-1:0]  start_index,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic              phy_ack,
  input  logic [DATA_W-1:0] phy_rdata,
  output logic              phy_req,
  output logic              phy_we,
  output logic              phy_group,
  output logic [IDX_W-1:0]  phy_index,
  output logic [DATA_W-1:0] phy_wdata,
  output logic [DATA_W-1:0] rd_data_q,
  output logic              done_flag,
  output logic              err_flag
);
  logic busy_q;
  logic accept_evt;
  logic resp_evt;
  logic tmo_evt;
  logic tmr_expire;
  logic tmr_en;

  assign accept_evt = start_evt && !busy_q;
  assign resp_evt   = busy_q && phy_ack && !clear_evt;
  assign tmr_en     = busy_q && !phy_ack && !clear_evt;
  assign tmo_evt    = tmr_expire;

  phy_bridge_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (accept_evt),
    .en     (tmr_en),
    .expire (tmr_expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      done_flag <= 1'b0;
      err_flag  <= 1'b0;
      phy_we    <= 1'b0;
      phy_group <= 1'b0;
      phy_index <= '0;
      phy_wdata <= '0;
      rd_data_q <= '0;
    end else if (clear_evt) begin
      busy_q    <= 1'b0;
      done_flag <= 1'b0;
      err_flag  <= 1'b0;
    end else if (accept_evt) begin
      busy_q    <= 1'b1;
      done_flag <= 1'b0;
      err_flag  <= 1'b0;
      phy_we    <= !start_read;
      phy_group <= start_group;
      phy_index <= start_index;
      phy_wdata <= start_wdata;
    end else if (resp_evt) begin
      busy_q    <= 1'b0;
      done_flag <= 1'b1;
      if (!phy_we) rd_data_q <= phy_rdata;
    end else if (tmo_evt) begin
      busy_q    <= 1'b0;
      err_flag  <= 1'b1;
    end
  end

  assign phy_req = busy_q;

  // R5: a pending request is held until answered, timed out or cleared
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req && !phy_ack && !tmo_evt && !clear_evt) |=> phy_req);

  // R5: an answer ends the request and raises done
  p_ack_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req && phy_ack && !clear_evt) |=> (done_flag && !phy_req));

  // R6: read data captured with the answer
  p_rdata_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req && phy_ack && !phy_we && !clear_evt) |=> (rd_data_q == $past(phy_rdata)));

  // R4: request fields do not move while the request is held
  p_fields_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req |=> (!phy_req || ($stable(phy_index) && $stable(phy_we) &&
                              $stable(phy_group) && $stable(phy_wdata))));

  // R7: a double request from idle leaves the bus idle
  p_bad_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_evt && !phy_req) |=> !phy_req);

  // R9: clearing the command word ends everything
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> (!phy_req && !done_flag && !err_flag));

  // R10: done and error never coexist
  p_done_err_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_flag && err_flag));

  // R11: with no request pending the done flag only holds or clears
  p_idle_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!phy_req && !clear_evt) |=> (done_flag == $past(done_flag)));

endmodule

// File: rtl/phy_reg_bridge.sv
module phy_reg_bridge #(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned IDX_W       = 8,
  parameter int unsigned TIMEOUT_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              phy_req,
  output logic              phy_we,
  output logic              phy_group,
  output logic [IDX_W-1:0]  phy_index,
  output logic [DATA_W-1:0] phy_wdata,
  output logic              phy_lane,
  input  logic              phy_ack,
  input  logic [DATA_W-1:0] phy_rdata,
  output logic              phy_rst,
  output logic              phy_soft_rst
);
  logic [IDX_W-1:0]  cmd_index;
  logic              cmd_read;
  logic              cmd_group;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rd_data_q;
  logic [1:0]        rst_bits_q;
  logic              lane_q;
  logic              done_flag;
  logic              err_flag;
  logic              start_evt;
  logic              clear_evt;
  logic              bad_evt;
  logic              start_read;
  logic              start_group;
  logic [IDX_W-1:0]  start_index;

  phy_bridge_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .rd_data_q  (rd_data_q),
    .done_flag  (done_flag),
    .err_flag   (err_flag),
    .cmd_index  (cmd_index),
    .cmd_read   (cmd_read),
    .cmd_group  (cmd_group),
    .wdata_q    (wdata_q),
    .lane_q     (lane_q),
    .rst_bits_q (rst_bits_q),
    .start_evt  (start_evt),
    .clear_evt  (clear_evt),
    .bad_evt    (bad_evt)
  );

  // the transaction takes its fields from the command being written
  assign start_index = host_wdata[IDX_W-1:0];
  assign start_read  = host_wdata[IDX_W+1];
  assign start_group = host_wdata[IDX_W+2];

  phy_bridge_xact #(
    .DATA_W      (DATA_W),
    .IDX_W       (IDX_W),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_xact (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_evt   (start_evt),
    .clear_evt   (clear_evt),
    .bad_evt     (bad_evt),
    .start_read  (start_read),
    .start_group (start_group),
    .start_index (start_index),
    .start_wdata (wdata_q),
    .phy_ack     (phy_ack),
    .phy_rdata   (phy_rdata),
    .phy_req     (phy_req),
    .phy_we      (phy_we),
    .phy_group   (phy_group),
    .phy_index   (phy_index),
    .phy_wdata   (phy_wdata),
    .rd_data_q   (rd_data_q),
    .done_flag   (done_flag),
    .err_flag    (err_flag)
  );

  assign phy_lane     = lane_q;
  assign phy_rst      = rst_bits_q[1];
  assign phy_soft_rst = rst_bits_q[0];

  // R4: a running request always matches a stored command (index agrees)
  p_req_matches_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req && !clear_evt) |-> (phy_index == cmd_index && phy_group == cmd_group &&
                                 phy_we == !cmd_read));

endmodule

// File: tb/sim_phy_reg_bridge.sv
`timescale 1ns/1ps
module sim_phy_reg_bridge;
  localparam int TMO = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        phy_req, phy_we, phy_group, phy_lane, phy_rst, phy_soft_rst;
  logic [7:0]  phy_index;
  logic [31:0] phy_wdata;
  logic        phy_ack;
  logic [31:0] phy_rdata;

  always #4 clk = ~clk;

  phy_reg_bridge #(.TIMEOUT_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .phy_req(phy_req),
    .phy_we(phy_we), .phy_group(phy_group), .phy_index(phy_index),
    .phy_wdata(phy_wdata), .phy_lane(phy_lane), .phy_ack(phy_ack),
    .phy_rdata(phy_rdata), .phy_rst(phy_rst), .phy_soft_rst(phy_soft_rst)
  );

  int n_chk = 0;
  int n_err = 0;

  // ---------------- PHY register-file responder ----------------
  logic [31:0] dev_mem [512];
  logic [31:0] exp_mem [512];
  logic        rsp_ack = 1'b0, rsp_done = 1'b0, mute = 1'b0, force_ack = 1'b0;
  logic [31:0] rsp_rdata = '0, force_rdata = '0;
  int          wcnt = 0, tgt = 0;
  logic [7:0]  cap_idx = '0;
  logic        cap_grp = 1'b0, cap_we = 1'b0, cap_lane = 1'b0;
  logic [31:0] cap_wd = '0;
  logic        req_d = 1'b0;
  int          n_rise = 0;

  assign phy_ack   = rsp_ack | force_ack;
  assign phy_rdata = force_ack ? force_rdata : rsp_rdata;

  always @(posedge clk) begin
    req_d <= phy_req;
    if (phy_req && !req_d) n_rise <= n_rise + 1;
    if (!phy_req) begin
      rsp_done <= 1'b0;
      wcnt     <= 0;
      tgt      <= $urandom_range(0, 5);
    end
    if (rsp_ack) rsp_ack <= 1'b0;
    else if (phy_req && !rsp_done && !mute) begin
      if (wcnt >= tgt) begin
        rsp_ack  <= 1'b1;
        rsp_done <= 1'b1;
        cap_idx  <= phy_index;
        cap_grp  <= phy_group;
        cap_we   <= phy_we;
        cap_wd   <= phy_wdata;
        cap_lane <= phy_lane;
        if (phy_we) begin
          dev_mem[{phy_group, phy_index}] <= phy_wdata;
          rsp_rdata <= $urandom;
        end else begin
          rsp_rdata <= dev_mem[{phy_group, phy_index}];
        end
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hr(input logic [4:0] a, output logic [31:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  function automatic logic [31:0] cmd_word(input bit rd, input bit grp,
                                           input logic [7:0] idx);
    return {21'b0, grp, rd, !rd, idx};
  endfunction

  logic [31:0] last_rd = '0;

  task automatic wait_status(output logic [31:0] v);
    int n = 0;
    hr(5'h14, v);
    while (v[1:0] == 2'b00 && n < 300) begin
      @(negedge clk);
      n++;
      hr(5'h14, v);
    end
  endtask

  task automatic run_op(input bit rd, input bit grp, input logic [7:0] idx,
                        input logic [31:0] wd);
    logic [31:0] v;
    int r0;
    hw(5'h04, wd);
    hw(5'h08, 32'd1);
    r0 = n_rise;
    hw(5'h00, cmd_word(rd, grp, idx));
    wait_status(v);
    chk(v[1:0] == 2'b01, "R5 done flag after answer", v, 32'd1);
    chk(n_rise == r0 + 1, "R4 exactly one request", n_rise, r0 + 1);
    chk(phy_req == 1'b0, "R5 request dropped", {31'b0, phy_req}, 0);
    chk({cap_grp, cap_idx} == {grp, idx}, "R4 group/index on bus",
        {23'b0, cap_grp, cap_idx}, {23'b0, grp, idx});
    chk(cap_we == !rd && cap_lane, "R4 direction and lane",
        {30'b0, cap_we, cap_lane}, {30'b0, !rd, 1'b1});
    hr(5'h10, v);
    if (rd) begin
      chk(v == exp_mem[{grp, idx}], "R6 read data captured", v, exp_mem[{grp, idx}]);
      last_rd = exp_mem[{grp, idx}];
    end else begin
      chk(cap_wd == wd, "R4 write data on bus", cap_wd, wd);
      chk(v == last_rd, "R6 write keeps read data", v, last_rd);
      exp_mem[{grp, idx}] = wd;
    end
    hw(5'h00, 32'd0);
    hr(5'h14, v);
    chk(v == 0, "R9 status cleared by idle write", v, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] v;
    int r0, n;
    void'($urandom(32'd1234));
    for (int i = 0; i < 512; i++) begin dev_mem[i] = '0; exp_mem[i] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      hr(5'(a * 4), v);
      chk(v == 0, "R1 register zero after reset", v, 0);
    end
    chk({phy_req, phy_rst, phy_soft_rst} == 3'b000, "R1 outputs idle",
        {29'b0, phy_req, phy_rst, phy_soft_rst}, 0);

    // R2 register map
    hw(5'h04, 32'hA5C3_0F96); hr(5'h04, v);
    chk(v == 32'hA5C3_0F96, "R2 write data readback", v, 32'hA5C3_0F96);
    hw(5'h08, 32'hFFFF_FFFF); hr(5'h08, v);
    chk(v == 32'd1, "R2 lane keeps bit0 only", v, 1);
    chk(phy_lane == 1'b1, "R4 lane output", {31'b0, phy_lane}, 1);
    hw(5'h10, 32'hFFFF_FFFF); hr(5'h10, v);
    chk(v == 0, "R2 read data not host writable", v, 0);
    hw(5'h14, 32'h3); hr(5'h14, v);
    chk(v == 0, "R2 status not host writable", v, 0);
    hr(5'h18, v); chk(v == 0, "R2 unused offset 0x18", v, 0);
    hr(5'h1C, v); chk(v == 0, "R2 unused offset 0x1C", v, 0);

    // R3 reset register
    hw(5'h0C, 32'h3); hr(5'h0C, v);
    chk(v == 3 && phy_rst && phy_soft_rst, "R3 both resets set", v, 3);
    hw(5'h0C, 32'h2);
    chk(phy_rst && !phy_soft_rst, "R3 main reset only", {30'b0, phy_rst, phy_soft_rst}, 2);
    hw(5'h0C, 32'h0);
    chk(!phy_rst && !phy_soft_rst, "R3 zero deasserts", {30'b0, phy_rst, phy_soft_rst}, 0);

    // directed transactions, both groups, same index
    run_op(1'b0, 1'b0, 8'h43, 32'h0020_0188);
    run_op(1'b0, 1'b1, 8'h43, 32'h1357_9BDF);
    run_op(1'b1, 1'b0, 8'h43, 32'h0);
    run_op(1'b1, 1'b1, 8'h43, 32'h0);
    run_op(1'b0, 1'b0, 8'h5A, 32'h0000_A061);
    run_op(1'b1, 1'b0, 8'h5A, 32'h0);

    // random transactions
    for (int k = 0; k < 40; k++) begin
      logic [7:0] ri;
      ri = 8'($urandom_range(0, 15)) + 8'h50;
      run_op(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), ri, $urandom);
    end

    // R7 double request ignored
    r0 = n_rise;
    hw(5'h00, 32'h0000_0343);
    repeat (6) @(negedge clk);
    chk(n_rise == r0 && !phy_req, "R7 double request starts nothing", n_rise, r0);
    hr(5'h00, v);
    chk(v == 32'h343, "R2 command word readback", v, 32'h343);
    // R8 rewrite while bits non-zero
    hw(5'h00, 32'h0000_0143);
    repeat (6) @(negedge clk);
    chk(n_rise == r0, "R8 no start from non-idle bits", n_rise, r0);
    hw(5'h00, 32'h0);

    // R8 after a completed write, done stays and no new request
    hw(5'h00, cmd_word(1'b0, 1'b0, 8'h60));
    wait_status(v);
    exp_mem[8'h60] = cap_wd;
    r0 = n_rise;
    hw(5'h00, cmd_word(1'b1, 1'b0, 8'h60));
    repeat (6) @(negedge clk);
    hr(5'h14, v);
    chk(n_rise == r0 && v == 1, "R8 done kept, no restart", v, 1);
    hw(5'h00, 32'h0);

    // R11 stray answer while idle
    r0 = n_rise;
    @(negedge clk);
    force_rdata = 32'hDEAD_BEEF; force_ack = 1'b1;
    @(negedge clk);
    force_ack = 1'b0;
    hr(5'h14, v); chk(v == 0, "R11 stray ack leaves status", v, 0);
    hr(5'h10, v); chk(v == last_rd, "R11 stray ack leaves read data", v, last_rd);
    chk(n_rise == r0, "R11 stray ack starts nothing", n_rise, r0);

    // R10 timeout
    mute = 1'b1;
    hw(5'h00, cmd_word(1'b1, 1'b0, 8'h52));
    n = 0;
    while (phy_req && n < 1000) begin n++; @(negedge clk); end
    chk(n == TMO, "R10 request length at timeout", n, TMO);
    hr(5'h14, v); chk(v == 32'd2, "R10 error set, done clear", v, 2);
    hr(5'h10, v); chk(v == last_rd, "R10 read data untouched", v, last_rd);
    hw(5'h00, 32'h0);
    hr(5'h14, v); chk(v == 0, "R9 error cleared by idle write", v, 0);

    // R9 withdraw in flight
    hw(5'h00, cmd_word(1'b0, 1'b1, 8'h52));
    repeat (3) @(negedge clk);
    chk(phy_req == 1'b1, "R9 request pending before clear", {31'b0, phy_req}, 1);
    hw(5'h00, 32'h0);
    chk(phy_req == 1'b0, "R9 request withdrawn", {31'b0, phy_req}, 0);
    repeat (TMO + 5) @(negedge clk);
    hr(5'h14, v); chk(v == 0, "R9 no late error after clear", v, 0);
    mute = 1'b0;

    // bridge still usable afterwards
    run_op(1'b1, 1'b0, 8'h60, 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule